// File: doc/BRIEF.md
# External Bus Read Wait-State Generator

This block sets how many clocks a read on an external memory bus lasts. The bus is divided into eight address areas. A read-wait register holds one enable bit per area, and a separate 2-bit long-wait count adds programmable delay to the slow area group. For each accepted read request, the block uses the space type, the area number and the register contents to pick a nominal length. It also decides whether the active-low WAIT input may stretch the access.

Bus state logic raises `req_i` while the block is idle. It then follows `busy_o`, which is high for every clock of the read, and `done_o`, which marks the final clock. The length is fixed when the request is accepted, so a register write made during a read does not disturb that read. When area 1 is plain external memory, a write of 0 to the area-1 write-wait bit is refused.

Top module: `bus_rdwait_gen`

## Requirements
- R1: After reset, `cfg_o` reads 16'hFFFF, the long-wait count is 3, and `busy_o` and `done_o` are low. An external read of area 0 with WAIT high at its sample point therefore takes 4 clocks.
- R2: External reads of areas 1, 3, 4, 5 and 7 whose read-wait bit is 0 take exactly 1 clock, and WAIT is ignored.
- R3: External reads of areas 1, 3, 4, 5 and 7 whose read-wait bit is 1 take 2 clocks plus one clock for every consecutive low sample of WAIT.
- R4: External reads of areas 0, 2 and 6 whose bit is 0 take 1 plus the long-wait count clocks, and WAIT is ignored.
- R5: External reads of areas 0, 2 and 6 whose bit is 1 take max(2, 1 + long-wait count) clocks plus WAIT extension.
- R6: DRAM column reads (space code 1) take 1 clock with WAIT ignored when the area bit is 0. They take 2 clocks plus WAIT extension when the bit is 1.
- R7: Space code 2 (multiplexed I/O) takes 4 clocks plus WAIT extension. Space code 3 (on-chip modules) takes a fixed 3 clocks. Space code 4 and the unused codes (on-chip memory) take a fixed 1 clock. None of these depends on the area bit.
- R8: `cfg_o[1]` is the area-1 write-wait bit. A write of 0 to it is stored only while `area1_dram_i` is high; otherwise the bit stays 1.
- R9: `busy_o` is high for every clock of a read. `done_o` is high only in its last clock and is followed by an idle clock. A request seen while busy is ignored.
- R10: A register write made during a read changes only later reads.
- R11: `cfg_o[15:8]` holds the read-wait bits, with bit 8+n belonging to area n. Bits 7:2 and bit 0 read as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Wait register write strobe |
| cfg_wdata_i | input | 16 | Wait register write data |
| lw_we_i | input | 1 | Long-wait count write strobe |
| lw_wdata_i | input | 2 | Long-wait count write data |
| area1_dram_i | input | 1 | Area 1 is configured as DRAM |
| cfg_o | output | 16 | Wait register readback |
| req_i | input | 1 | Read access request, accepted when idle |
| space_i | input | 3 | Space code: 0 external, 1 DRAM, 2 mux I/O, 3 on-chip module, 4 on-chip memory |
| area_i | input | 3 | Area number 0 to 7 |
| wait_ni | input | 1 | Active-low WAIT from the bus |
| busy_o | output | 1 | Read access in progress |
| done_o | output | 1 | Last clock of the read access |

## Verification
The bench builds the block with `SYNC_STAGES` set to 0, so the WAIT level in a given clock decides that clock's outcome directly. This makes every extension clock predictable from the stimulus, and exact access lengths can be compared. The area count and long-wait width keep their defaults, so all eight areas and the full long-wait range from 0 to 3, including the reset maximum, can be reached. In rows where WAIT must be ignored, the bench holds WAIT low for the whole access, so that any wrong sampling shows up as a longer read.

// File: rtl/rdwait_pkg.sv
package rdwait_pkg;
  typedef enum logic [2:0] {
    SPC_EXT    = 3'd0,
    SPC_DRAM   = 3'd1,
    SPC_MUXIO  = 3'd2,
    SPC_PERIPH = 3'd3,
    SPC_ONCHIP = 3'd4
  } space_e;
endpackage

// File: rtl/rdwait_cfg.sv
module rdwait_cfg #(
  parameter int AREAS = 8,
  parameter int LW_W  = 2,
  localparam int REG_W = 2 * AREAS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [REG_W-1:0] cfg_wdata_i,
  input  logic             lw_we_i,
  input  logic [LW_W-1:0]  lw_wdata_i,
  input  logic             area1_dram_i,
  output logic [AREAS-1:0] rw_o,
  output logic             ww1_o,
  output logic [LW_W-1:0]  lw_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rw_o  <= '1;
      ww1_o <= 1'b1;
      lw_o  <= '1;
    end else begin
      if (cfg_we_i) begin
        rw_o  <= cfg_wdata_i[REG_W-1:AREAS];
        // clearing is legal only for a DRAM area 1
        ww1_o <= cfg_wdata_i[1] | ~area1_dram_i;
      end
      if (lw_we_i) lw_o <= lw_wdata_i;
    end
  end
endmodule

// File: rtl/rdwait_sync.sv
module rdwait_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign q_o = d_i;
    end else begin : g_chain
      logic [STAGES-1:0] sr_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr_q <= '1;
        else         sr_q <= {sr_q[STAGES-2+1-1:0], d_i} >> 0;
      end
      assign q_o = sr_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/rdwait_len.sv
module rdwait_len
  import rdwait_pkg::*;
#(
  parameter int          AREAS      = 8,
  parameter int          LW_W       = 2,
  parameter int          PERIPH_CYC = 3,
  parameter int          MUX_CYC    = 4,
  parameter int          CNT_W      = 4,
  parameter logic [AREAS-1:0] LONG_MASK = 8'b0100_0101,
  localparam int         AW         = $clog2(AREAS)
) (
  input  logic [2:0]       space_i,
  input  logic [AW-1:0]    area_i,
  input  logic [AREAS-1:0] rw_i,
  input  logic [LW_W-1:0]  lw_i,
  output logic [CNT_W-1:0] len_o,
  output logic             samp_o
);
  space_e     spc;
  logic       rw_bit;
  logic       long_grp;
  logic [CNT_W-1:0] lw_len;

  assign spc      = space_e'(space_i);
  assign rw_bit   = rw_i[area_i];
  assign long_grp = LONG_MASK[area_i];
  assign lw_len   = CNT_W'(1) + CNT_W'(lw_i);

  always_comb begin
    len_o  = CNT_W'(1);
    samp_o = 1'b0;
    unique case (spc)
      SPC_EXT: begin
        if (long_grp) begin
          samp_o = rw_bit;
          if (rw_bit && lw_i == '0) len_o = CNT_W'(2);
          else                      len_o = lw_len;
        end else if (rw_bit) begin
          samp_o = 1'b1;
          len_o  = CNT_W'(2);
        end
      end
      SPC_DRAM: begin
        samp_o = rw_bit;
        len_o  = rw_bit ? CNT_W'(2) : CNT_W'(1);
      end
      SPC_MUXIO: begin
        samp_o = 1'b1;
        len_o  = CNT_W'(MUX_CYC);
      end
      SPC_PERIPH: len_o = CNT_W'(PERIPH_CYC);
      default: ;
    endcase
  end
endmodule

// File: rtl/rdwait_fsm.sv
module rdwait_fsm #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [CNT_W-1:0] len_i,
  input  logic             samp_i,
  input  logic             wait_n_i,
  output logic             busy_o,
  output logic             done_o
);
  logic             busy_q;
  logic             samp_q;
  logic [CNT_W-1:0] cnt_q;
  logic             last;
  logic             hold;

  assign last   = busy_q && (cnt_q == CNT_W'(1));
  assign hold   = last && samp_q && !wait_n_i;
  assign done_o = last && !hold;
  assign busy_o = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      samp_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!busy_q) begin
      if (req_i) begin
        busy_q <= 1'b1;
        samp_q <= samp_i;
        cnt_q  <= len_i;
      end
    end else if (done_o) begin
      busy_q <= 1'b0;
    end else if (!last) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end
endmodule

// File: rtl/bus_rdwait_gen.sv
module bus_rdwait_gen #(
  parameter int AREAS       = 8,
  parameter int LW_W        = 2,
  parameter int SYNC_STAGES = 2,
  parameter int PERIPH_CYC  = 3,
  parameter int MUX_CYC     = 4,
  localparam int AW         = $clog2(AREAS),
  localparam int REG_W      = 2 * AREAS,
  localparam int CNT_W      = $clog2(MUX_CYC + PERIPH_CYC + (1 << LW_W) + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [REG_W-1:0] cfg_wdata_i,
  input  logic             lw_we_i,
  input  logic [LW_W-1:0]  lw_wdata_i,
  input  logic             area1_dram_i,
  output logic [REG_W-1:0] cfg_o,
  input  logic             req_i,
  input  logic [2:0]       space_i,
  input  logic [AW-1:0]    area_i,
  input  logic             wait_ni,
  output logic             busy_o,
  output logic             done_o
);
  logic [AREAS-1:0] rw;
  logic             ww1;
  logic [LW_W-1:0]  lw;
  logic [CNT_W-1:0] len;
  logic             samp;
  logic             wait_n_s;

  rdwait_cfg #(.AREAS(AREAS), .LW_W(LW_W)) u_cfg (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_wdata_i, .lw_we_i, .lw_wdata_i,
    .area1_dram_i, .rw_o(rw), .ww1_o(ww1), .lw_o(lw)
  );

  rdwait_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(wait_ni), .q_o(wait_n_s)
  );

  rdwait_len #(
    .AREAS(AREAS), .LW_W(LW_W), .PERIPH_CYC(PERIPH_CYC),
    .MUX_CYC(MUX_CYC), .CNT_W(CNT_W)
  ) u_len (
    .space_i, .area_i, .rw_i(rw), .lw_i(lw), .len_o(len), .samp_o(samp)
  );

  rdwait_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk_i, .rst_ni, .req_i, .len_i(len), .samp_i(samp),
    .wait_n_i(wait_n_s), .busy_o, .done_o
  );

  assign cfg_o = {rw, {(AREAS-2){1'b1}}, ww1, 1'b1};
endmodule

// File: rtl/bus_rdwait_gen_chk.sv
module bus_rdwait_gen_chk #(
  parameter int AREAS = 8
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 cfg_we_i,
  input logic [2*AREAS-1:0]   cfg_wdata_i,
  input logic                 area1_dram_i,
  input logic [2*AREAS-1:0]   cfg_o,
  input logic                 req_i,
  input logic                 busy_o,
  input logic                 done_o
);
  p_done_in_acc_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o);
  p_done_ends_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!busy_o && !done_o));
  p_busy_holds_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o);
  p_start_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !busy_o) |=> busy_o);
  p_ww1_kept_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && !area1_dram_i) |=> cfg_o[1]);
  p_cfg_stable_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_we_i |=> $stable(cfg_o));
  p_rw_load_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> (cfg_o[2*AREAS-1:AREAS] == $past(cfg_wdata_i[2*AREAS-1:AREAS])));
endmodule

bind bus_rdwait_gen bus_rdwait_gen_chk #(.AREAS(AREAS)) u_chk (.*);

// File: tb/bus_rdwait_gen_test.sv
module bus_rdwait_gen_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [15:0] cfg_wdata_i = '0;
  logic        lw_we_i = 1'b0;
  logic [1:0]  lw_wdata_i = '0;
  logic        area1_dram_i = 1'b0;
  logic [15:0] cfg_o;
  logic        req_i = 1'b0;
  logic [2:0]  space_i = '0;
  logic [2:0]  area_i = '0;
  logic        wait_ni = 1'b1;
  logic        busy_o, done_o;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  bus_rdwait_gen #(.SYNC_STAGES(0)) uut (
    .clk_i(clk), .rst_ni, .cfg_we_i, .cfg_wdata_i, .lw_we_i, .lw_wdata_i,
    .area1_dram_i, .cfg_o, .req_i, .space_i, .area_i, .wait_ni,
    .busy_o, .done_o
  );

  // hi: access clock index from which WAIT is driven high (31 = never)
  typedef struct packed {
    logic [2:0] spc;
    logic [2:0] area;
    logic [7:0] rw;
    logic [1:0] lw;
    logic [4:0] hi;
    logic [4:0] exp;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{3'd0, 3'd1, 8'h00, 2'd0, 5'd31, 5'd1, 4'd2},  // R2
    '{3'd0, 3'd7, 8'hFF, 2'd0, 5'd1,  5'd2, 4'd3},  // R3
    '{3'd0, 3'd3, 8'hFF, 2'd0, 5'd4,  5'd5, 4'd3},  // R3
    '{3'd0, 3'd0, 8'h00, 2'd2, 5'd31, 5'd3, 4'd4},  // R4
    '{3'd0, 3'd6, 8'h00, 2'd0, 5'd31, 5'd1, 4'd4},  // R4
    '{3'd0, 3'd2, 8'hFF, 2'd0, 5'd2,  5'd3, 4'd5},  // R5
    '{3'd0, 3'd0, 8'hFF, 2'd3, 5'd5,  5'd6, 4'd5},  // R5
    '{3'd1, 3'd1, 8'h00, 2'd0, 5'd31, 5'd1, 4'd6},  // R6
    '{3'd1, 3'd4, 8'hFF, 2'd0, 5'd3,  5'd4, 4'd6},  // R6
    '{3'd2, 3'd5, 8'h00, 2'd0, 5'd4,  5'd5, 4'd7},  // R7
    '{3'd3, 3'd0, 8'hFF, 2'd3, 5'd31, 5'd3, 4'd7},  // R7
    '{3'd4, 3'd2, 8'hFF, 2'd0, 5'd31, 5'd1, 4'd7},  // R7
    '{3'd0, 3'd4, 8'hEF, 2'd0, 5'd31, 5'd1, 4'd2},  // R2 per-area bit
    '{3'd0, 3'd5, 8'hEF, 2'd0, 5'd2,  5'd3, 4'd3}   // R3 per-area bit
  };

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic wr_cfg(input logic [15:0] d);
    @(negedge clk);
    cfg_we_i = 1'b1; cfg_wdata_i = d;
    @(negedge clk);
    cfg_we_i = 1'b0;
  endtask

  task automatic wr_lw(input logic [1:0] d);
    @(negedge clk);
    lw_we_i = 1'b1; lw_wdata_i = d;
    @(negedge clk);
    lw_we_i = 1'b0;
  endtask

  task automatic run_acc(input logic [2:0] spc, input logic [2:0] area,
                         input int hi, input bit mid_wr, input logic [15:0] mid_d,
                         input bit hold_req, output int len);
    @(negedge clk);
    space_i = spc; area_i = area; req_i = 1'b1; wait_ni = 1'b1;
    @(posedge clk);
    len = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      req_i   = hold_req;
      wait_ni = (i >= hi);
      if (mid_wr && i == 0) begin
        cfg_we_i = 1'b1; cfg_wdata_i = mid_d;
      end else begin
        cfg_we_i = 1'b0;
      end
      #1;
      if (!busy_o) break;
      len++;
      if (done_o) break;
    end
    @(negedge clk);
    req_i = 1'b0; cfg_we_i = 1'b0; wait_ni = 1'b1;
    #1;
    // R9: idle clock after the last one, no stray re-acceptance
    chk(!busy_o && !done_o, "R9", {busy_o, done_o}, 0);
  endtask

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int len;
    #1;
    chk(busy_o == 1'b0 && done_o == 1'b0, "R1", {busy_o, done_o}, 0);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    #1;
    chk(cfg_o == 16'hFFFF, "R1", cfg_o, 16'hFFFF);
    // reset bits all 1, long-wait 3: area 0 external = 4 clocks
    run_acc(3'd0, 3'd0, 3, 1'b0, '0, 1'b0, len);
    chk(len == 4, "R1", len, 4);

    for (int v = 0; v < NV; v++) begin
      wr_cfg({VEC[v].rw, 8'hFF});
      wr_lw(VEC[v].lw);
      run_acc(VEC[v].spc, VEC[v].area, int'(VEC[v].hi), 1'b0, '0, 1'b0, len);
      chk(len == int'(VEC[v].exp), $sformatf("R%0d row %0d", VEC[v].req, v),
          len, int'(VEC[v].exp));
    end

    // R8 / R11: area-1 write-wait protection and register layout
    area1_dram_i = 1'b0;
    wr_cfg(16'h0000);
    #1;
    chk(cfg_o == 16'h00FF, "R8", cfg_o, 16'h00FF);
    area1_dram_i = 1'b1;
    wr_cfg(16'h0000);
    #1;
    chk(cfg_o == 16'h00FD, "R8", cfg_o, 16'h00FD);
    wr_cfg(16'hA502);
    #1;
    chk(cfg_o == 16'hA5FF, "R11", cfg_o, 16'hA5FF);
    area1_dram_i = 1'b0;

    // R10: clear area 3 bit mid-access; current read keeps 2 + WAIT
    wr_cfg(16'hFFFF);
    wr_lw(2'd0);
    run_acc(3'd0, 3'd3, 2, 1'b1, 16'h00FF, 1'b0, len);
    chk(len == 3, "R10", len, 3);
    run_acc(3'd0, 3'd3, 31, 1'b0, '0, 1'b0, len);
    chk(len == 1, "R10", len, 1);

    // R9: request held high through the access yields one access only
    wr_cfg(16'hFFFF);
    run_acc(3'd2, 3'd1, 3, 1'b0, '0, 1'b1, len);
    chk(len == 4, "R9", len, 4);

    finish_run();
  end
endmodule